// File: doc/BRIEF.md
# Ring-Oscillator Entropy Sampling Unit

This block collects bits from a bank of free-running oscillator inputs and turns them into 64-bit words that software pulls from an on-chip word queue. The 128 oscillator inputs form 16 groups of eight. A single control write picks the operating mode and the active group. Bits in the same write can also clear the generator, empty the queue, or both.

Three production modes exist. In raw mode the chosen group of eight is sampled once per clock for eight clocks, and those 64 samples form one word. The conditioned and deterministic modes use a 64-bit Galois LFSR as a stand-in mixer and emit one word every 81 clocks. Conditioned mode also XOR-folds all oscillator inputs into the mixer state on every step. Deterministic mode ignores the oscillators, so its word sequence after a reseed is always the same. Generation pauses while the queue is full and resumes as soon as a word is read. A status bit reports the self-test result, which is always a pass here.

Top module: `rng_entropy_unit`

## Requirements
- R1: After synchronous reset `rd_data` is 0, `fill_level` is 0, `underflow` is 0 and `selftest_fail` is 0. The unit is off and produces no words until it is enabled.
- R2: Control word fields are: bit 0 enable, bit 1 entropy enable, bit 2 raw expose, bits 6:3 group select, bit 7 generator reset, bit 8 queue reset. Any write with bit 7 or bit 8 set stores an all-zero control value, so production stops.
- R3: In raw mode (bits 0, 1 and 2 set) one word enters the queue every 8 clocks. The first word becomes visible in `fill_level` 8 clock edges after the control write edge.
- R4: In a raw word, bit 8*k+j holds sample j of oscillator k of the selected group. Sample 0 is the oldest.
- R5: Oscillator k of group g is input `ro_in[8*g+k]`. Inputs outside the selected group do not affect raw words.
- R6: In deterministic mode (bit 0 set, bit 1 clear) the mixer steps once per clock. It reseeds to 64'h6A09E667F3BCC908 on reset or on a bit-7 write. One step is s>>1, XORed with 64'hD800000000000000 when s[0] is 1. Every 81st step places the new state in the queue, and oscillator inputs have no effect.
- R7: In conditioned mode (bits 0 and 1 set, bit 2 clear) each step also XORs `ro_in[63:0] ^ ro_in[127:64]` into the stepped state. A word is still produced every 81 clocks.
- R8: The queue holds 64 words. When it is full, generation stalls with the sample phase held. No word is lost or overwritten.
- R9: A pulse on `rd_en` places the oldest queued word on `rd_data` after the next edge, and `rd_data` holds until the next read. A read from an empty queue returns 0 and sets the sticky `underflow` flag.
- R10: A write with bit 8 set empties the queue, clears `underflow` and zeroes `rd_data`.
- R11: Every control write restarts the production phase. The new mode first advances on the edge after the write.
- R12: Raw expose with entropy enable clear behaves exactly as deterministic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 9 | Control word (fields per R2) |
| ro_in | input | 128 | Oscillator sample inputs |
| rd_en | input | 1 | Pop one word from the queue |
| rd_data | output | 64 | Last word read |
| fill_level | output | 7 | Words currently queued |
| underflow | output | 1 | Sticky empty-read flag |
| selftest_fail | output | 1 | Self-test result, 0 means pass |

## Verification
After a control write edge, the first raw word shows up in `fill_level` 8 edges later, and the first mixer word shows up 81 edges later. Read data appears on the edge right after `rd_en`, and a queue reset takes effect on the write edge itself. The bench keeps a behavioural model that is updated on each rising edge from the inputs it drove. It compares every output against this model at the falling edge, half a period after the registers settle. Directed checks wait an exact edge count after each stimulus, counted from the write edge. They look one edge before and on the edge where a word becomes due, so a single-cycle shift in latency shows up as a failure.

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam int NUM_OSC     = 128;
    localparam int GROUP_W     = 8;
    localparam int WORD_W      = 64;
    localparam int NUM_GROUPS  = NUM_OSC / GROUP_W;
    localparam int GRP_SEL_W   = $clog2(NUM_GROUPS);

    localparam logic [WORD_W-1:0] MIX_SEED = 64'h6A09E667F3BCC908;
    localparam logic [WORD_W-1:0] MIX_TAPS = 64'hD800000000000000;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_DET  = 2'd1,
        MODE_COND = 2'd2,
        MODE_RAW  = 2'd3
    } gen_mode_e;

    // Packed MSB first: bit 8 queue reset ... bit 0 enable
    typedef struct packed {
        logic                 q_rst;
        logic                 gen_rst;
        logic [GRP_SEL_W-1:0] grp;
        logic                 raw;
        logic                 ent;
        logic                 en;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    function automatic logic [WORD_W-1:0] mix_step(input logic [WORD_W-1:0] s);
        return {1'b0, s[WORD_W-1:1]} ^ (s[0] ? MIX_TAPS : '0);
    endfunction

    function automatic logic [WORD_W-1:0] fold_osc(input logic [NUM_OSC-1:0] ro);
        logic [WORD_W-1:0] acc;
        acc = '0;
        for (int c = 0; c < NUM_OSC / WORD_W; c++)
            acc = acc ^ ro[c*WORD_W +: WORD_W];
        return acc;
    endfunction

endpackage

// File: rtl/rng_ctl.sv
module rng_ctl
    import rng_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  ctl_word_t            wdata,
    output gen_mode_e            mode,
    output logic [GRP_SEL_W-1:0] grp,
    output logic                 gen_reseed,
    output logic                 q_flush
);

    ctl_word_t cur;

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (wr) begin
            if (wdata.gen_rst || wdata.q_rst)
                cur <= '0;
            else
                cur <= wdata;
        end
    end

    always_comb begin
        if (!cur.en)
            mode = MODE_OFF;
        else if (!cur.ent)
            mode = MODE_DET;
        else if (cur.raw)
            mode = MODE_RAW;
        else
            mode = MODE_COND;
    end

    assign grp        = cur.grp;
    assign gen_reseed = wr && wdata.gen_rst;
    assign q_flush    = wr && wdata.q_rst;

    AST_RESET_DISABLES: assert property (@(posedge clk) disable iff (rst)
        wr && (wdata.gen_rst || wdata.q_rst) |=> mode == MODE_OFF); // R2

endmodule

// File: rtl/rng_raw_packer.sv
module rng_raw_packer
    import rng_pkg::*;
#(
    parameter int N_OSC   = NUM_OSC,
    parameter int GRP_W   = GROUP_W,
    parameter int OUT_W   = WORD_W,
    parameter int SEL_W   = GRP_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [SEL_W-1:0] grp,
    input  logic [N_OSC-1:0] ro_in,
    output logic             push_o,
    output logic [OUT_W-1:0] word_o
);

    localparam int SAMPLES = OUT_W / GRP_W;
    localparam int PH_W    = $clog2(SAMPLES);

    logic [PH_W-1:0]  phase;
    logic [OUT_W-1:0] acc;
    logic [GRP_W-1:0] pick;

    assign pick   = ro_in[int'(grp)*GRP_W +: GRP_W];
    assign push_o = adv && (phase == PH_W'(SAMPLES-1));

    always_comb begin
        word_o = acc;
        for (int k = 0; k < GRP_W; k++)
            word_o[k*SAMPLES + int'(phase)] = pick[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            acc   <= '0;
        end else if (clr) begin
            phase <= '0;
        end else if (adv) begin
            acc   <= word_o;
            phase <= push_o ? '0 : phase + 1'b1;
        end
    end

    AST_RAW_SPACING: assert property (@(posedge clk) disable iff (rst)
        push_o |=> !push_o); // R3

endmodule

// File: rtl/rng_mixer.sv
module rng_mixer
    import rng_pkg::*;
#(
    parameter int LATENCY = 81
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reseed,
    input  logic               clr,
    input  logic               adv,
    input  logic               fold_en,
    input  logic [NUM_OSC-1:0] ro_in,
    output logic               push_o,
    output logic [WORD_W-1:0]  word_o
);

    localparam int CNT_W = $clog2(LATENCY);

    logic [WORD_W-1:0] state;
    logic [CNT_W-1:0]  phase;

    assign word_o = mix_step(state) ^ (fold_en ? fold_osc(ro_in) : '0);
    assign push_o = adv && (phase == CNT_W'(LATENCY-1));

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            state <= MIX_SEED;
            phase <= '0;
        end else if (clr) begin
            phase <= '0;
        end else if (adv) begin
            state <= word_o;
            phase <= push_o ? '0 : phase + 1'b1;
        end
    end

    AST_MIX_SPACING: assert property (@(posedge clk) disable iff (rst)
        push_o |=> !push_o); // R6

endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       underflow
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          pop;

    assign full = (count == CW'(DEPTH));
    assign pop  = rd_en && (count != '0);

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush && !rst)
            mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr      <= '0;
            rptr      <= '0;
            count     <= '0;
            rd_data   <= '0;
            underflow <= 1'b0;
        end else begin
            if (rd_en) begin
                if (pop) begin
                    rd_data <= mem[rptr];
                    rptr    <= bump(rptr);
                end else begin
                    rd_data   <= '0;
                    underflow <= 1'b1;
                end
            end
            if (push)
                wptr <= bump(wptr);
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> count < CW'(DEPTH)); // R8
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_en && count == '0 && !flush |=> rd_data == '0 && underflow); // R9
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == '0 && !underflow); // R10

endmodule

// File: rtl/rng_entropy_unit.sv
module rng_entropy_unit
    import rng_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int MIX_LATENCY = 81
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ctl_wr,
    input  logic [CTL_W-1:0]                ctl_wdata,
    input  logic [NUM_OSC-1:0]              ro_in,
    input  logic                            rd_en,
    output logic [WORD_W-1:0]               rd_data,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fill_level,
    output logic                            underflow,
    output logic                            selftest_fail
);

    gen_mode_e            mode;
    logic [GRP_SEL_W-1:0] grp;
    logic                 gen_reseed, q_flush, full, adv;
    logic                 raw_push, mix_push;
    logic [WORD_W-1:0]    raw_word, mix_word;

    rng_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .wr         (ctl_wr),
        .wdata      (ctl_word_t'(ctl_wdata)),
        .mode       (mode),
        .grp        (grp),
        .gen_reseed (gen_reseed),
        .q_flush    (q_flush)
    );

    // A control write restarts the phase, so no step happens on that edge.
    assign adv = (mode != MODE_OFF) && !full && !ctl_wr;

    rng_raw_packer u_raw (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctl_wr),
        .adv    (adv && mode == MODE_RAW),
        .grp    (grp),
        .ro_in  (ro_in),
        .push_o (raw_push),
        .word_o (raw_word)
    );

    rng_mixer #(.LATENCY(MIX_LATENCY)) u_mix (
        .clk     (clk),
        .rst     (rst),
        .reseed  (gen_reseed),
        .clr     (ctl_wr),
        .adv     (adv && (mode == MODE_DET || mode == MODE_COND)),
        .fold_en (mode == MODE_COND),
        .ro_in   (ro_in),
        .push_o  (mix_push),
        .word_o  (mix_word)
    );

    rng_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (q_flush),
        .push      (raw_push || mix_push),
        .wdata     (raw_push ? raw_word : mix_word),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .count     (fill_level),
        .full      (full),
        .underflow (underflow)
    );

    // Self-test logic is not modelled; the result always reports a pass.
    assign selftest_fail = 1'b0;

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !(raw_push && mix_push)); // R11

endmodule

// File: tb/rng_entropy_unit_test.sv
`timescale 1ns/1ps
module rng_entropy_unit_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctl_wr = 1'b0;
    logic [8:0]   ctl_wdata = '0;
    logic [127:0] ro_in = '0;
    logic         rd_en = 1'b0;
    logic [63:0]  rd_data;
    logic [6:0]   fill_level;
    logic         underflow;
    logic         selftest_fail;

    int n_checks = 0;
    int n_errors = 0;
    bit cmp_en = 0;
    bit ro_rand = 1;
    logic [127:0] ro_fixed = '0;

    always #2 clk = ~clk;

    rng_entropy_unit uut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ro_in(ro_in), .rd_en(rd_en), .rd_data(rd_data),
        .fill_level(fill_level), .underflow(underflow),
        .selftest_fail(selftest_fail)
    );

    localparam logic [63:0] SEED = 64'h6A09E667F3BCC908;
    localparam logic [63:0] TAPS = 64'hD800000000000000;

    function automatic logic [63:0] ref_step(input logic [63:0] s);
        logic [63:0] r;
        r = s >> 1;
        if (s[0]) r = r ^ TAPS;
        return r;
    endfunction

    // ---------------- reference model ----------------
    logic [63:0] m_q[$];
    logic [63:0] m_rd;
    bit          m_uf;
    int          m_mode;   // 0 off, 1 det, 2 cond, 3 raw
    int          m_grp;
    int          m_phase;
    logic [63:0] m_lfsr;
    logic [7:0]  m_smp[8];

    always @(posedge clk) begin
        bit          adv, do_push;
        logic [63:0] pw;
        do_push = 0;
        pw = '0;
        if (rst) begin
            m_q.delete(); m_rd = '0; m_uf = 0; m_mode = 0; m_grp = 0;
            m_phase = 0; m_lfsr = SEED;
        end else begin
            adv = (m_mode != 0) && (m_q.size() < 64) && !ctl_wr;
            if (adv) begin
                if (m_mode == 3) begin
                    for (int k = 0; k < 8; k++) m_smp[k][m_phase] = ro_in[m_grp*8 + k];
                    if (m_phase == 7) begin
                        for (int k = 0; k < 8; k++)
                            for (int j = 0; j < 8; j++) pw[8*k + j] = m_smp[k][j];
                        do_push = 1; m_phase = 0;
                    end else m_phase++;
                end else begin
                    m_lfsr = ref_step(m_lfsr);
                    if (m_mode == 2) m_lfsr = m_lfsr ^ ro_in[63:0] ^ ro_in[127:64];
                    m_phase++;
                    if (m_phase == 81) begin pw = m_lfsr; do_push = 1; m_phase = 0; end
                end
            end
            if (ctl_wr) begin
                m_phase = 0;
                if (ctl_wdata[7] || ctl_wdata[8]) begin
                    m_mode = 0; m_grp = 0;
                end else begin
                    m_grp = int'(ctl_wdata[6:3]);
                    if (!ctl_wdata[0]) m_mode = 0;
                    else if (!ctl_wdata[1]) m_mode = 1;
                    else if (ctl_wdata[2]) m_mode = 3;
                    else m_mode = 2;
                end
                if (ctl_wdata[7]) m_lfsr = SEED;
            end
            if (ctl_wr && ctl_wdata[8]) begin
                m_q.delete(); m_rd = '0; m_uf = 0;
            end else begin
                if (rd_en) begin
                    if (m_q.size() > 0) m_rd = m_q.pop_front();
                    else begin m_rd = '0; m_uf = 1; end
                end
                if (do_push) m_q.push_back(pw);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison, half a period after the registers update
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(rd_data === m_rd, "R9 rd_data vs model", rd_data, m_rd);
            chk(int'(fill_level) == m_q.size(), "R8 fill_level vs model",
                64'(fill_level), 64'(m_q.size()));
            chk(underflow === m_uf, "R9 underflow vs model", 64'(underflow), 64'(m_uf));
            chk(selftest_fail === 1'b0, "R1 selftest_fail", 64'(selftest_fail), 64'd0);
        end
    end

    always @(negedge clk)
        ro_in <= ro_rand ? {$urandom(), $urandom(), $urandom(), $urandom()} : ro_fixed;

    task automatic wr_ctl(input logic [8:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic rd_word(output logic [63:0] w);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        #0.1 w = rd_data;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [63:0] w, w_det, w_det2, exp_w;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_en = 1;
        @(negedge clk);
        // R1: reset state and unit off
        chk(rd_data == 0 && fill_level == 0 && !underflow, "R1 reset outputs",
            {rd_data[55:0], fill_level, underflow}, 64'd0);
        wait_edges(100);
        chk(fill_level == 0, "R1 no words while off", 64'(fill_level), 64'd0);

        // R6: deterministic latency and value
        wr_ctl(9'h001);
        wait_edges(80);
        chk(fill_level == 0, "R6 no word at edge 80", 64'(fill_level), 64'd0);
        wait_edges(1);
        chk(fill_level == 1, "R6 word at edge 81", 64'(fill_level), 64'd1);
        rd_word(w_det);
        exp_w = SEED;
        for (int i = 0; i < 81; i++) exp_w = ref_step(exp_w);
        chk(w_det == exp_w, "R6 first deterministic word", w_det, exp_w);

        // R6: reproducible after reseed, oscillators ignored
        wr_ctl(9'h180);
        wr_ctl(9'h001);
        wait_edges(81);
        rd_word(w_det2);
        chk(w_det2 == w_det, "R6 reproducible after reseed", w_det2, w_det);

        // R12: raw expose without entropy enable acts as deterministic
        wr_ctl(9'h180);
        wr_ctl(9'h005);
        wait_edges(81);
        rd_word(w);
        chk(w == w_det, "R12 raw without entropy is deterministic", w, w_det);

        // R7: conditioned mode folds oscillators in
        wr_ctl(9'h180);
        wr_ctl(9'h003);
        wait_edges(80);
        chk(fill_level == 0, "R7 no word at edge 80", 64'(fill_level), 64'd0);
        wait_edges(1);
        chk(fill_level == 1, "R7 word at edge 81", 64'(fill_level), 64'd1);
        rd_word(w);
        chk(w != w_det, "R7 conditioned differs from deterministic", w, ~w_det);

        // R3: raw latency
        wr_ctl(9'h100);
        wr_ctl(9'h007);
        wait_edges(7);
        chk(fill_level == 0, "R3 no raw word at edge 7", 64'(fill_level), 64'd0);
        wait_edges(1);
        chk(fill_level == 1, "R3 raw word at edge 8", 64'(fill_level), 64'd1);
        wait_edges(8);
        chk(fill_level == 2, "R3 second raw word at edge 16", 64'(fill_level), 64'd2);

        // R4: bit layout, oscillator 3 of group 2 held high
        ro_fixed = 128'd1 << 19;
        ro_rand = 0;
        wr_ctl(9'h100);
        wr_ctl(9'h017);
        wait_edges(8);
        rd_word(w);
        chk(w == 64'h00000000FF000000, "R4 raw bit layout", w, 64'h00000000FF000000);

        // R5: group 3 does not see an input of group 2
        wr_ctl(9'h100);
        wr_ctl(9'h01F);
        wait_edges(8);
        rd_word(w);
        chk(w == 64'd0, "R5 other group ignored", w, 64'd0);
        ro_rand = 1;

        // R11: rewrite restarts phase
        wr_ctl(9'h100);
        wr_ctl(9'h007);
        wait_edges(5);
        wr_ctl(9'h007);
        wait_edges(7);
        chk(fill_level == 0, "R11 phase restarted", 64'(fill_level), 64'd0);
        wait_edges(1);
        chk(fill_level == 1, "R11 word 8 edges after rewrite", 64'(fill_level), 64'd1);

        // R8: fill to full, stall, resume
        wr_ctl(9'h100);
        wr_ctl(9'h02F);
        wait_edges(64*8 + 20);
        chk(fill_level == 64, "R8 queue full", 64'(fill_level), 64'd64);
        rd_word(w);
        chk(fill_level == 63, "R8 one slot freed", 64'(fill_level), 64'd63);
        wait_edges(7);
        chk(fill_level == 63, "R8 stalled phase held", 64'(fill_level), 64'd63);
        wait_edges(1);
        chk(fill_level == 64, "R8 refilled after 8 edges", 64'(fill_level), 64'd64);
        for (int i = 0; i < 10; i++) rd_word(w);

        // R2: generator reset write stops production
        wr_ctl(9'h100);
        wr_ctl(9'h001);
        wait_edges(40);
        wr_ctl(9'h080);
        wait_edges(100);
        chk(fill_level == 0, "R2 reset bit disables", 64'(fill_level), 64'd0);

        // R9: empty read
        rd_word(w);
        chk(w == 0 && underflow, "R9 empty read zero and flag", {w[62:0], underflow}, 64'd1);
        wait_edges(3);
        chk(underflow, "R9 underflow sticky", 64'(underflow), 64'd1);

        // R10: queue reset clears flag
        wr_ctl(9'h100);
        chk(!underflow && fill_level == 0 && rd_data == 0, "R10 flush clears",
            {rd_data[55:0], fill_level, underflow}, 64'd0);

        wait_edges(2);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule